// File: doc/BRIEF.md
# Skewed Matrix Bank Mapper

This block does the address generation and data alignment for a small array processor. The processor has four processing elements and keeps a 4x4 matrix in five single-cycle memory banks. The elements are laid out with a rotating skew: each row is shifted one bank further than the row above it. Because of this layout, a whole row, a whole column or the main diagonal always sits in four different banks. The whole vector can then be fetched in one memory cycle with no bank conflict.

For a read, the caller gives an access mode and an index. The block raises the enable of the four banks that hold the wanted vector and gives each of those banks its word address. It also keeps track of which bank serves which processing element. One cycle later the banks return their words, and an alignment crossbar puts them on the processor lanes in logical order. Lane k always receives the k-th element of the vector.

A write request stores one element at its skewed location. While it does, it blocks any read requested in the same cycle.

Top module: `skew_bank_mapper`

## Requirements
- R1: While reset is held and after it is released, with no request present, `pe_valid` is 0 and all bank enables and write enables are 0.
- R2: In row mode (`rd_mode`=0) with index r, lane k receives element (r,k). Element (i,j), counted from 0, is stored in bank (i+j) mod 5 at word address i.
- R3: In column mode (`rd_mode`=1) with index c, lane k receives element (k,c). For that lane the block enables bank (k+c) mod 5 at word address k.
- R4: In diagonal mode (`rd_mode`=2), lane k receives element (k,k), read from bank (2k) mod 5 at word address k. The index is ignored.
- R5: Every accepted read enables exactly four distinct banks, one for each lane. The fifth bank stays disabled.
- R6: The aligned vector appears on `pe_data` with `pe_valid`=1 in the cycle after the request. The banks return read data one cycle after they are enabled.
- R7: A write of element (i,j) enables only bank (i+j) mod 5, with its write enable set and word address i. `wr_data` is driven on that bank's write-data slice.
- R8: A read requested in the same cycle as a write is ignored. No read enables are raised, and `pe_valid` stays 0 in the next cycle.
- R9: Mode 3 is reserved. A read request with it raises no bank enable and produces no `pe_valid`.
- R10: Bank write enables are 0 in every cycle that has no write request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Vector read request |
| rd_mode | input | 2 | 0 row, 1 column, 2 diagonal, 3 reserved |
| rd_index | input | 2 | Row or column number |
| wr_req | input | 1 | Single-element write request |
| wr_row | input | 2 | Row of element to write |
| wr_col | input | 2 | Column of element to write |
| wr_data | input | 8 | Element value to write |
| bank_en | output | 5 | Per-bank access enable |
| bank_we | output | 5 | Per-bank write enable |
| bank_addr | output | 10 | Per-bank word address, 2 bits per bank, bank b at [2b+1:2b] |
| bank_wdata | output | 40 | Per-bank write data, bank b at [8b+7:8b] |
| bank_rdata | input | 40 | Per-bank read data, one cycle after enable |
| pe_valid | output | 1 | Aligned vector present on pe_data |
| pe_data | output | 32 | Lane k at [8k+7:8k] |

## Verification
The bench writes a distinct value into every one of the 16 elements. It then reads every row, every column and the diagonal, checking the bank enables and addresses of each access as well as the lane order of the returned vector. A wrong skew or a wrong modulo shows up in two ways: two lanes ask for the same bank, so the enable count drops below four, and a lane receives another element's value. A crossbar that does not keep its select for the returned cycle puts words on the wrong lanes.

Three further cases are covered:
- A read and a write in the same cycle. A design that lets the read through produces an unexpected vector, and it may also raise extra enables beside the written bank.
- A request in the reserved mode. A design that treats it as a real mode raises enables and a spurious `pe_valid`.
- A second read of the overwritten element. This confirms that the collision write landed at its skewed location.

// File: rtl/skew_pkg.sv
package skew_pkg;

  typedef enum logic [1:0] {
    MODE_ROW  = 2'd0,
    MODE_COL  = 2'd1,
    MODE_DIAG = 2'd2,
    MODE_RSVD = 2'd3
  } access_mode_e;

  // Bank that holds matrix element (row, col) under the rotating skew.
  function automatic int unsigned bank_of(input int unsigned row,
                                          input int unsigned col,
                                          input int unsigned nbank);
    return (row + col) % nbank;
  endfunction

endpackage

// File: rtl/skew_addr_gen.sv
module skew_addr_gen
  import skew_pkg::*;
#(
  parameter int DIM   = 4,
  parameter int NBANK = DIM + 1,
  localparam int AW   = $clog2(DIM),
  localparam int BW   = $clog2(NBANK)
) (
  input  logic [1:0]                rd_mode,
  input  logic [AW-1:0]             rd_index,
  output logic                      mode_ok,
  output logic [DIM-1:0][BW-1:0]    lane_bank,
  output logic [DIM-1:0][AW-1:0]    lane_addr
);

  assign mode_ok = (access_mode_e'(rd_mode) != MODE_RSVD);

  for (genvar k = 0; k < DIM; k++) begin : g_lane
    logic [AW-1:0] elem_row;
    logic [AW-1:0] elem_col;

    always_comb begin
      case (access_mode_e'(rd_mode))
        MODE_ROW: begin
          elem_row = rd_index;
          elem_col = AW'(k);
        end
        MODE_COL: begin
          elem_row = AW'(k);
          elem_col = rd_index;
        end
        default: begin
          elem_row = AW'(k);
          elem_col = AW'(k);
        end
      endcase
    end

    assign lane_bank[k] = BW'(bank_of(32'(elem_row), 32'(elem_col), NBANK));
    assign lane_addr[k] = elem_row;
  end

endmodule

// File: rtl/skew_bank_drive.sv
module skew_bank_drive
  import skew_pkg::*;
#(
  parameter int DIM   = 4,
  parameter int NBANK = DIM + 1,
  localparam int AW   = $clog2(DIM),
  localparam int BW   = $clog2(NBANK)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_go,
  input  logic [DIM-1:0][BW-1:0]    lane_bank,
  input  logic [DIM-1:0][AW-1:0]    lane_addr,
  input  logic                      wr_req,
  input  logic [AW-1:0]             wr_row,
  input  logic [AW-1:0]             wr_col,
  output logic [NBANK-1:0]          bank_en,
  output logic [NBANK-1:0]          bank_we,
  output logic [NBANK-1:0][AW-1:0]  bank_addr
);

  logic [BW-1:0] wr_bank;
  assign wr_bank = BW'(bank_of(32'(wr_row), 32'(wr_col), NBANK));

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_comb begin
      bank_en[b]   = 1'b0;
      bank_we[b]   = 1'b0;
      bank_addr[b] = '0;
      if (wr_req) begin
        if (wr_bank == BW'(b)) begin
          bank_en[b]   = 1'b1;
          bank_we[b]   = 1'b1;
          bank_addr[b] = wr_row;
        end
      end else if (rd_go) begin
        for (int k = 0; k < DIM; k++) begin
          if (lane_bank[k] == BW'(b)) begin
            bank_en[b]   = 1'b1;
            bank_addr[b] = lane_addr[k];
          end
        end
      end
    end
  end

  AST_READ_FOUR_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |-> ($countones(bank_en) == DIM)); // R5

  AST_WRITE_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> ($countones(bank_en) == 1 && bank_we == bank_en)); // R7

  AST_NO_WE_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req |-> (bank_we == '0)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_req && !rd_go) |-> (bank_en == '0)); // R9

endmodule

// File: rtl/skew_align_xbar.sv
module skew_align_xbar #(
  parameter int DIM   = 4,
  parameter int NBANK = DIM + 1,
  parameter int DW    = 8,
  localparam int BW   = $clog2(NBANK)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_go,
  input  logic [DIM-1:0][BW-1:0]    lane_bank,
  input  logic [NBANK-1:0][DW-1:0]  bank_rdata,
  output logic                      pe_valid,
  output logic [DIM-1:0][DW-1:0]    pe_data
);

  logic [DIM-1:0][BW-1:0] sel_q, sel_d;
  logic                   valid_q, valid_d;

  always_comb begin
    sel_d   = sel_q;
    valid_d = rd_go;
    if (rd_go) begin
      sel_d = lane_bank;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      sel_q   <= sel_d;
      valid_q <= valid_d;
    end
  end

  assign pe_valid = valid_q;

  for (genvar k = 0; k < DIM; k++) begin : g_lane
    assign pe_data[k] = bank_rdata[sel_q[k]];
  end

  logic [NBANK-1:0] sel_mask;
  always_comb begin
    sel_mask = '0;
    for (int k = 0; k < DIM; k++) begin
      sel_mask[sel_q[k]] = 1'b1;
    end
  end

  AST_LANES_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    pe_valid |-> ($countones(sel_mask) == DIM)); // R5

endmodule

// File: rtl/skew_bank_mapper.sv
module skew_bank_mapper
  import skew_pkg::*;
#(
  parameter int DIM   = 4,
  parameter int NBANK = DIM + 1,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DIM),
  localparam int BW   = $clog2(NBANK)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_req,
  input  logic [1:0]            rd_mode,
  input  logic [AW-1:0]         rd_index,
  input  logic                  wr_req,
  input  logic [AW-1:0]         wr_row,
  input  logic [AW-1:0]         wr_col,
  input  logic [DW-1:0]         wr_data,
  output logic [NBANK-1:0]      bank_en,
  output logic [NBANK-1:0]      bank_we,
  output logic [NBANK*AW-1:0]   bank_addr,
  output logic [NBANK*DW-1:0]   bank_wdata,
  input  logic [NBANK*DW-1:0]   bank_rdata,
  output logic                  pe_valid,
  output logic [DIM*DW-1:0]     pe_data
);

  logic                      mode_ok;
  logic                      rd_go;
  logic [DIM-1:0][BW-1:0]    lane_bank;
  logic [DIM-1:0][AW-1:0]    lane_addr;
  logic [NBANK-1:0][AW-1:0]  addr_vec;
  logic [NBANK-1:0][DW-1:0]  rdata_vec;
  logic [DIM-1:0][DW-1:0]    lane_data;

  assign rd_go = rd_req && mode_ok && !wr_req;

  skew_addr_gen #(.DIM(DIM), .NBANK(NBANK)) u_addr (
    .rd_mode   (rd_mode),
    .rd_index  (rd_index),
    .mode_ok   (mode_ok),
    .lane_bank (lane_bank),
    .lane_addr (lane_addr)
  );

  skew_bank_drive #(.DIM(DIM), .NBANK(NBANK)) u_drive (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_go     (rd_go),
    .lane_bank (lane_bank),
    .lane_addr (lane_addr),
    .wr_req    (wr_req),
    .wr_row    (wr_row),
    .wr_col    (wr_col),
    .bank_en   (bank_en),
    .bank_we   (bank_we),
    .bank_addr (addr_vec)
  );

  assign bank_addr  = addr_vec;
  assign bank_wdata = {NBANK{wr_data}};
  assign rdata_vec  = bank_rdata;

  skew_align_xbar #(.DIM(DIM), .NBANK(NBANK), .DW(DW)) u_xbar (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_go      (rd_go),
    .lane_bank  (lane_bank),
    .bank_rdata (rdata_vec),
    .pe_valid   (pe_valid),
    .pe_data    (lane_data)
  );

  assign pe_data = lane_data;

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_mode != 2'd3 && !wr_req) |=> pe_valid); // R6

  AST_COLLISION_DROPS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !pe_valid); // R8

  AST_RESERVED_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == 2'd3 || !rd_req) |=> !pe_valid); // R9

endmodule

// File: tb/tb_skew_bank_mapper.sv
module tb_skew_bank_mapper;
  localparam int CLK_PERIOD = 10;
  localparam int DIM = 4;
  localparam int NB  = 5;
  localparam int DW  = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              rd_req;
  logic [1:0]        rd_mode;
  logic [1:0]        rd_index;
  logic              wr_req;
  logic [1:0]        wr_row, wr_col;
  logic [DW-1:0]     wr_data;
  logic [NB-1:0]     bank_en, bank_we;
  logic [NB*2-1:0]   bank_addr;
  logic [NB*DW-1:0]  bank_wdata;
  logic [NB*DW-1:0]  bank_rdata;
  logic              pe_valid;
  logic [DIM*DW-1:0] pe_data;

  int tests = 0;
  int fails = 0;
  logic [DW-1:0] mem [NB][DIM];
  logic [DW-1:0] exp_m [DIM][DIM];
  logic [DIM*DW-1:0] sb_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  skew_bank_mapper dut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_mode(rd_mode),
    .rd_index(rd_index), .wr_req(wr_req), .wr_row(wr_row), .wr_col(wr_col),
    .wr_data(wr_data), .bank_en(bank_en), .bank_we(bank_we),
    .bank_addr(bank_addr), .bank_wdata(bank_wdata), .bank_rdata(bank_rdata),
    .pe_valid(pe_valid), .pe_data(pe_data)
  );

  // Bench model of five single-cycle banks.
  always @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (bank_en[b]) begin
        if (bank_we[b]) mem[b][bank_addr[b*2 +: 2]] <= bank_wdata[b*DW +: DW];
        else bank_rdata[b*DW +: DW] <= mem[b][bank_addr[b*2 +: 2]];
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard when an aligned vector appears.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && pe_valid === 1'b1) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R8/R9", "unexpected pe_valid", 64'(pe_data), 64'h0);
      end else begin
        logic [DIM*DW-1:0] e;
        e = sb_q.pop_front();
        check(pe_data == e, "R6", "aligned vector", 64'(pe_data), 64'(e));
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    rd_req = 1'b0; wr_req = 1'b0;
  endtask

  task automatic do_read(input int mode, input int idx, input string req);
    logic [NB-1:0]     emask;
    logic [DIM*DW-1:0] evec;
    @(negedge clk);
    wr_req = 1'b0; rd_req = 1'b1; rd_mode = 2'(mode); rd_index = 2'(idx);
    #1;
    if (mode == 3) begin
      check(bank_en == '0, "R9", "reserved mode enables", 64'(bank_en), 64'h0);
      return;
    end
    emask = '0;
    for (int k = 0; k < DIM; k++) begin
      int r, c, b;
      r = (mode == 0) ? idx : k;
      c = (mode == 1) ? idx : k;
      b = (r + c) % NB;
      emask[b] = 1'b1;
      evec[k*DW +: DW] = exp_m[r][c];
      check(bank_addr[b*2 +: 2] == 2'(r), req, "bank word address",
            64'(bank_addr[b*2 +: 2]), 64'(r));
    end
    check(bank_en == emask, req, "bank enable pattern", 64'(bank_en), 64'(emask));
    check($countones(bank_en) == DIM, "R5", "enable count",
          64'($countones(bank_en)), 64'(DIM));
    check(bank_we == '0, "R10", "write enables during read", 64'(bank_we), 64'h0);
    sb_q.push_back(evec);
  endtask

  task automatic do_write(input int r, input int c, input logic [DW-1:0] d,
                          input bit with_read);
    int b;
    @(negedge clk);
    wr_req = 1'b1; wr_row = 2'(r); wr_col = 2'(c); wr_data = d;
    rd_req = with_read; rd_mode = 2'd1; rd_index = 2'(c);
    #1;
    b = (r + c) % NB;
    check(bank_en == NB'(1 << b), with_read ? "R8" : "R7", "write enables",
          64'(bank_en), 64'(1 << b));
    check(bank_we == NB'(1 << b), "R7", "write strobe", 64'(bank_we), 64'(1 << b));
    check(bank_addr[b*2 +: 2] == 2'(r), "R7", "write address",
          64'(bank_addr[b*2 +: 2]), 64'(r));
    check(bank_wdata[b*DW +: DW] == d, "R7", "write data",
          64'(bank_wdata[b*DW +: DW]), 64'(d));
    exp_m[r][c] = d;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    check(1'b0, "R6", "watchdog expired", 64'h0, 64'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rd_req = 1'b0; rd_mode = '0; rd_index = '0;
    wr_req = 1'b0; wr_row = '0; wr_col = '0; wr_data = '0;
    bank_rdata = '0;
    repeat (3) @(posedge clk);
    #1;
    check(pe_valid == 1'b0, "R1", "pe_valid in reset", 64'(pe_valid), 64'h0);
    check(bank_en == '0, "R1", "enables in reset", 64'(bank_en), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(pe_valid == 1'b0, "R1", "pe_valid after reset", 64'(pe_valid), 64'h0);
    check(bank_en == '0 && bank_we == '0, "R1", "enables after reset",
          64'({bank_en, bank_we}), 64'h0);

    // Fill the matrix: element (i,j) = i*16 + j + 1.
    for (int i = 0; i < DIM; i++)
      for (int j = 0; j < DIM; j++)
        do_write(i, j, DW'(i * 16 + j + 1), 1'b0);
    idle();

    for (int r = 0; r < DIM; r++) do_read(0, r, "R2");
    for (int c = 0; c < DIM; c++) do_read(1, c, "R3");
    do_read(2, 0, "R4");
    do_read(2, 3, "R4");
    idle();
    idle();

    // Reserved mode: nothing enabled, no vector returned.
    do_read(3, 1, "R9");
    idle();
    idle();

    // Collision: write (2,1) with a column read requested in the same cycle.
    do_write(2, 1, 8'hA5, 1'b1);
    idle();
    idle();
    do_read(1, 1, "R7");
    do_read(0, 2, "R2");
    idle();
    idle();
    idle();

    check(sb_q.size() == 0, "R6", "vectors never returned",
          64'(sb_q.size()), 64'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule